// File: doc/BRIEF.md
# Device Context Table Walker

This block turns the identity of a DMA requester (an 8-bit bus number and an 8-bit device/function number) into the translation context that governs its memory accesses. It does this with a two-step walk through memory. First it fetches a 128-bit root entry, selected by the bus number, from a root table whose base address comes with the request. If that entry is present, it fetches a 128-bit context entry, selected by devfn, from the context table that the root entry points to.

The context entry is then decoded into a page-table root, an address-width code with its matching page-table level count, a domain identifier and a translation type. If the walk cannot complete, the block returns a fault code instead. A context entry can ask for its faults to be handled quietly; in that case the fault carries a suppression flag.

Only one lookup is handled at a time. The block raises `busy` from the moment it accepts a request until its result has been taken. Memory reads use a plain valid/ready request channel and a response channel that delivers one beat per request.

Top module: `ctx_walker`

## Requirements
- R1: After reset, `busy`, `res_valid` and `mem_req_valid` are low.
- R2: The first read of a lookup is at address root_base + bus*16.
- R3: If bit 0 of the root entry's low 64 bits is clear, the result has fault code 1, suppression 0 and all context fields zero, and no second read is made.
- R4: If the root entry is present, the second read is at {root_lo[AW-1:12], 12'h000} + devfn*16.
- R5: If context bit 0 is clear, the result has fault code 2 and all context fields zero.
- R6: On success (fault code 0) the outputs are as follows. `res_pt_root` is {ctx_lo[AW-1:12], 12'h000}. `res_ttype` is ctx_lo[3:2], where 0 means untranslated requests only, 1 means all requests and 2 means passthrough. `res_aw_code` is ctx_hi[2:0]. `res_domain` is ctx_hi[11:8], and other high-word bits are ignored. (ctx_lo is entry bits 63:0; ctx_hi is bits 127:64.)
- R7: On success, `res_levels` is 2, 3, 4, 5 or 6 for address-width codes 0 (30 bits), 1 (39), 2 (48), 3 (57) and 4 (64) respectively.
- R8: A present context entry with an address-width code of 5 to 7, or a translation type of 3, gives fault code 3 with all context fields zero.
- R9: `res_suppress` equals ctx_lo[1] (fault-processing disable) when the fault code is 2 or 3. It is 0 on success and for root faults.
- R10: `busy` is high from the cycle after acceptance until the result handshake. `req_valid` is ignored while busy, and the result is held until `res_ready`.
- R11: A memory request stays valid with a stable address until `mem_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request, accepted when not busy |
| req_bus | input | 8 | Requester bus number |
| req_devfn | input | 8 | Requester device/function number |
| req_root_base | input | AW | Root table base address |
| busy | output | 1 | Lookup in progress |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | AW | Byte address of 128-bit read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 128 | Read data |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result taken |
| res_fault_code | output | 2 | 0 ok, 1 root absent, 2 context absent, 3 malformed |
| res_suppress | output | 1 | Fault reporting suppressed |
| res_pt_root | output | AW | Second-level page-table root |
| res_aw_code | output | 3 | Address-width code |
| res_levels | output | 3 | Page-table level count |
| res_domain | output | 4 | Domain identifier |
| res_ttype | output | 2 | Translation type |

## Verification
The assertions assume several things about the environment. The memory side returns exactly one response beat per accepted read and never returns a beat while no read is pending. The consumer raises `res_ready` only while `res_valid` is high. The root base is aligned to 16 bytes. The bench's memory responder answers only after it has accepted a request, with a varying number of stall cycles. Its result monitor withholds `res_ready` for a varying number of cycles before taking each result, and every root base it drives is 4 KiB aligned.

// File: rtl/ctxw_pkg.sv
package ctxw_pkg;

  localparam int ENTRY_BITS = 128;
  localparam int PAGE_SHIFT = 12;
  localparam int ENTRY_SHIFT = 4;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_ROOT_REQ  = 3'd1,
    ST_ROOT_WAIT = 3'd2,
    ST_CTX_REQ   = 3'd3,
    ST_CTX_WAIT  = 3'd4,
    ST_DONE      = 3'd5
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE        = 2'd0,
    FLT_ROOT_ABSENT = 2'd1,
    FLT_CTX_ABSENT  = 2'd2,
    FLT_MALFORMED   = 2'd3
  } fault_e;

  typedef struct packed {
    fault_e      fault;
    logic        suppress;
    logic [1:0]  ttype;
    logic [2:0]  aw_code;
    logic [2:0]  levels;
    logic [3:0]  domain;
  } ctx_info_t;

endpackage

// File: rtl/ctxw_index_addr.sv
module ctxw_index_addr #(
  parameter int AW        = 48,
  parameter bit MASK_PAGE = 1'b0
) (
  input  logic [AW-1:0] base,
  input  logic [7:0]    idx,
  output logic [AW-1:0] addr
);
  import ctxw_pkg::*;

  localparam int PAD_W = AW - 8 - ENTRY_SHIFT;

  logic [AW-1:0] base_eff;
  logic [AW-1:0] offset;

  generate
    if (MASK_PAGE) begin : g_page
      assign base_eff = {base[AW-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    end else begin : g_raw
      assign base_eff = base;
    end
  endgenerate

  assign offset = {{PAD_W{1'b0}}, idx, {ENTRY_SHIFT{1'b0}}};
  assign addr   = base_eff + offset;

endmodule

// File: rtl/ctxw_ctx_decode.sv
module ctxw_ctx_decode #(
  parameter int AW = 48
) (
  input  logic [63:0]         lo,
  input  logic [63:0]         hi,
  output ctxw_pkg::ctx_info_t info,
  output logic [AW-1:0]       pt_root
);
  import ctxw_pkg::*;

  logic       present;
  logic       fpd;
  logic [1:0] tt;
  logic [2:0] aw;
  logic       malformed;

  assign present   = lo[0];
  assign fpd       = lo[1];
  assign tt        = lo[3:2];
  assign aw        = hi[2:0];
  assign malformed = (aw > 3'd4) || (tt == 2'd3);

  always_comb begin
    info    = '0;
    pt_root = '0;
    if (!present) begin
      info.fault    = FLT_CTX_ABSENT;
      info.suppress = fpd;
    end else if (malformed) begin
      info.fault    = FLT_MALFORMED;
      info.suppress = fpd;
    end else begin
      info.fault   = FLT_NONE;
      info.ttype   = tt;
      info.aw_code = aw;
      info.levels  = aw + 3'd2;
      info.domain  = hi[11:8];
      pt_root      = {lo[AW-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    end
  end

endmodule

// File: rtl/ctx_walker.sv
module ctx_walker #(
  parameter int AW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [7:0]    req_bus,
  input  logic [7:0]    req_devfn,
  input  logic [AW-1:0] req_root_base,
  output logic          busy,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [127:0]  mem_rsp_data,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [1:0]    res_fault_code,
  output logic          res_suppress,
  output logic [AW-1:0] res_pt_root,
  output logic [2:0]    res_aw_code,
  output logic [2:0]    res_levels,
  output logic [3:0]    res_domain,
  output logic [1:0]    res_ttype
);
  import ctxw_pkg::*;

  walk_state_e   st_q, st_d;
  logic [7:0]    bus_q, devfn_q;
  logic [AW-1:0] base_q, ctx_base_q;
  ctx_info_t     res_q, res_d;
  logic [AW-1:0] root_q, root_d;
  logic          load_req, load_ctx, load_res;

  logic [AW-1:0] root_addr, ctx_addr;
  ctx_info_t     dec_info;
  logic [AW-1:0] dec_root;

  ctxw_index_addr #(.AW(AW), .MASK_PAGE(1'b0)) u_root_addr (
    .base(base_q), .idx(bus_q), .addr(root_addr)
  );

  ctxw_index_addr #(.AW(AW), .MASK_PAGE(1'b1)) u_ctx_addr (
    .base(ctx_base_q), .idx(devfn_q), .addr(ctx_addr)
  );

  ctxw_ctx_decode #(.AW(AW)) u_decode (
    .lo(mem_rsp_data[63:0]), .hi(mem_rsp_data[127:64]),
    .info(dec_info), .pt_root(dec_root)
  );

  // next-state
  always_comb begin
    st_d     = st_q;
    load_req = 1'b0;
    load_ctx = 1'b0;
    load_res = 1'b0;
    res_d    = dec_info;
    root_d   = dec_root;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        st_d     = ST_ROOT_REQ;
        load_req = 1'b1;
      end
      ST_ROOT_REQ: if (mem_req_ready) st_d = ST_ROOT_WAIT;
      ST_ROOT_WAIT: if (mem_rsp_valid) begin
        if (mem_rsp_data[0]) begin
          st_d     = ST_CTX_REQ;
          load_ctx = 1'b1;
        end else begin
          st_d        = ST_DONE;
          load_res    = 1'b1;
          res_d       = '0;
          res_d.fault = FLT_ROOT_ABSENT;
          root_d      = '0;
        end
      end
      ST_CTX_REQ: if (mem_req_ready) st_d = ST_CTX_WAIT;
      ST_CTX_WAIT: if (mem_rsp_valid) begin
        st_d     = ST_DONE;
        load_res = 1'b1;
      end
      ST_DONE: if (res_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q   <= '0;
      devfn_q <= '0;
      base_q  <= '0;
    end else if (load_req) begin
      bus_q   <= req_bus;
      devfn_q <= req_devfn;
      base_q  <= req_root_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_base_q <= '0;
    end else if (load_ctx) begin
      ctx_base_q <= mem_rsp_data[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      root_q <= '0;
    end else if (load_res) begin
      res_q  <= res_d;
      root_q <= root_d;
    end
  end

  assign busy          = (st_q != ST_IDLE);
  assign mem_req_valid = (st_q == ST_ROOT_REQ) || (st_q == ST_CTX_REQ);
  assign mem_req_addr  = (st_q == ST_CTX_REQ) ? ctx_addr : root_addr;
  assign res_valid     = (st_q == ST_DONE);
  assign res_fault_code = res_q.fault;
  assign res_suppress  = res_q.suppress;
  assign res_pt_root   = root_q;
  assign res_aw_code   = res_q.aw_code;
  assign res_levels    = res_q.levels;
  assign res_domain    = res_q.domain;
  assign res_ttype     = res_q.ttype;

  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_res_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_fault_code)
      && $stable(res_pt_root) && $stable(res_domain) && $stable(res_suppress)));

  assert_busy_on_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> busy);

  assert_req_res_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && res_valid));

  assert_root_fault_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault_code == FLT_ROOT_ABSENT) |->
      (!res_suppress && res_pt_root == '0 && res_domain == '0 && res_levels == '0));

  assert_fault_fields_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault_code != FLT_NONE) |->
      (res_pt_root == '0 && res_aw_code == '0 && res_ttype == '0 && res_domain == '0));

  assert_success_wellformed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault_code == FLT_NONE) |->
      (res_aw_code <= 3'd4 && res_ttype != 2'd3 && !res_suppress));

endmodule

// File: tb/ctx_walker_test.sv
module ctx_walker_test;
  localparam int AW = 48;

  typedef struct {
    logic [1:0]    fault;
    logic          sup;
    logic [AW-1:0] pt;
    logic [2:0]    aw;
    logic [2:0]    lv;
    logic [3:0]    dom;
    logic [1:0]    tt;
    int            nreads;
  } exp_t;

  logic          clk, rst_n;
  logic          req_valid;
  logic [7:0]    req_bus, req_devfn;
  logic [AW-1:0] req_root_base;
  logic          busy, mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [AW-1:0] mem_req_addr;
  logic [127:0]  mem_rsp_data;
  logic          res_valid, res_ready, res_suppress;
  logic [1:0]    res_fault_code, res_ttype;
  logic [AW-1:0] res_pt_root;
  logic [2:0]    res_aw_code, res_levels;
  logic [3:0]    res_domain;

  int n_tests = 0;
  int n_fail  = 0;

  ctx_walker #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bus(req_bus),
    .req_devfn(req_devfn), .req_root_base(req_root_base), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_fault_code(res_fault_code), .res_suppress(res_suppress),
    .res_pt_root(res_pt_root), .res_aw_code(res_aw_code),
    .res_levels(res_levels), .res_domain(res_domain), .res_ttype(res_ttype)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // environment shared by driver, responder and monitor
  exp_t          sb_q[$];
  logic [127:0]  root_ent, ctx_ent;
  logic [AW-1:0] exp_addr [2];
  int            rd_cnt;
  int            stall;
  int            hold;
  int            results_seen;

  function automatic exp_t model(input logic [127:0] re, input logic [127:0] ce);
    exp_t e;
    e = '{fault: 2'd0, sup: 1'b0, pt: '0, aw: 3'd0, lv: 3'd0, dom: 4'd0,
          tt: 2'd0, nreads: 2};
    if (!re[0]) begin
      e.fault = 2'd1; e.nreads = 1;
      return e;
    end
    if (!ce[0]) begin
      e.fault = 2'd2; e.sup = ce[1];
    end else if (ce[66:64] > 3'd4 || ce[3:2] == 2'd3) begin
      e.fault = 2'd3; e.sup = ce[1];
    end else begin
      e.pt  = {ce[AW-1:12], 12'h000};
      e.aw  = ce[66:64];
      e.dom = ce[75:72];
      e.tt  = ce[3:2];
      case (ce[66:64])
        3'd0: e.lv = 3'd2;
        3'd1: e.lv = 3'd3;
        3'd2: e.lv = 3'd4;
        3'd3: e.lv = 3'd5;
        default: e.lv = 3'd6;
      endcase
    end
    return e;
  endfunction

  // driver
  task automatic lookup(input logic [7:0] bus, input logic [7:0] devfn,
                        input logic [AW-1:0] base, input logic [127:0] re,
                        input logic [127:0] ce, input int st, input int hd,
                        input bit poke);
    int target;
    while (busy) @(negedge clk);
    root_ent    = re;
    ctx_ent     = ce;
    exp_addr[0] = base + {32'd0, bus, 4'h0};
    exp_addr[1] = {re[AW-1:12], 12'h000} + {32'd0, devfn, 4'h0};
    rd_cnt      = 0;
    stall       = st;
    hold        = hd;
    target      = results_seen + 1;
    sb_q.push_back(model(re, ce));
    req_valid = 1'b1; req_bus = bus; req_devfn = devfn; req_root_base = base;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy === 1'b1, "R10 busy after accept", {63'd0, busy}, 64'd1);
    if (poke) begin
      req_valid = 1'b1; req_bus = ~bus; req_devfn = ~devfn;
      req_root_base = base + 48'h1000;
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
    end
    while (results_seen != target) @(negedge clk);
  endtask

  // memory responder
  initial begin
    int  sc;
    bit  pend;
    logic [127:0] d;
    sc = 0; pend = 1'b0; d = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      if (mem_req_valid) begin
        if (rd_cnt < 2)
          check(mem_req_addr === exp_addr[rd_cnt],
                (rd_cnt == 0) ? "R2 root read address" : "R4 context read address R11",
                {16'd0, mem_req_addr}, {16'd0, exp_addr[rd_cnt]});
        else
          check(1'b0, "R3 unexpected extra read", rd_cnt, 2);
        if (sc < stall) sc++;
        else begin
          sc = 0;
          mem_req_ready = 1'b1;
          d = (rd_cnt == 0) ? root_ent : ctx_ent;
          rd_cnt++;
          pend = 1'b1;
        end
      end else if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = d;
        pend = 1'b0;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    int wc;
    exp_t e;
    wc = 0; results_seen = 0; res_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (res_ready) begin
        res_ready = 1'b0;
        results_seen++;
      end else if (res_valid) begin
        if (wc < hold) begin
          check(busy === 1'b1, "R10 busy while result waits", {63'd0, busy}, 64'd1);
          wc++;
        end else begin
          wc = 0;
          if (sb_q.size() == 0) begin
            check(1'b0, "R10 result with empty scoreboard", 1, 0);
          end else begin
            e = sb_q.pop_front();
            check(res_fault_code === e.fault, "R3 R5 R8 fault code", res_fault_code, e.fault);
            check(res_suppress === e.sup, "R9 suppress", res_suppress, e.sup);
            check(res_pt_root === e.pt, "R6 pt root", {16'd0, res_pt_root}, {16'd0, e.pt});
            check(res_aw_code === e.aw, "R6 aw code", res_aw_code, e.aw);
            check(res_levels === e.lv, "R7 levels", res_levels, e.lv);
            check(res_domain === e.dom, "R6 domain", res_domain, e.dom);
            check(res_ttype === e.tt, "R6 ttype", res_ttype, e.tt);
            check(rd_cnt == e.nreads, "R3 read count", rd_cnt, e.nreads);
          end
          res_ready = 1'b1;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic logic [127:0] ctx(input logic [35:0] pg, input logic [2:0] aw,
                                       input logic [7:0] dom8, input logic [1:0] tt,
                                       input bit fpd, input bit pres);
    logic [127:0] c;
    c = '0;
    c[47:12]  = pg;
    c[3:2]    = tt;
    c[1]      = fpd;
    c[0]      = pres;
    c[66:64]  = aw;
    c[79:72]  = dom8;
    c[127:100] = 28'hABCDEF1;
    return c;
  endfunction

  initial begin
    logic [127:0] rp;
    req_valid = 1'b0; req_bus = '0; req_devfn = '0; req_root_base = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R1 busy at reset", {63'd0, busy}, 0);
    check(res_valid === 1'b0, "R1 res_valid at reset", {63'd0, res_valid}, 0);
    check(mem_req_valid === 1'b0, "R1 mem_req_valid at reset", {63'd0, mem_req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    rp = '0; rp[47:12] = 36'h0_1234_5; rp[0] = 1'b1; rp[100] = 1'b1;
    // R6 R7: 39-bit width, untranslated-only type
    lookup(8'h00, 8'h08, 48'h0000_8000_0000, rp, ctx(36'hA_BCDE_F, 3'd1, 8'h05, 2'd0, 0, 1), 0, 0, 0);
    // R6 R7 R9: 48-bit width, passthrough, fpd set on success
    lookup(8'hFF, 8'hFB, 48'h0012_3456_7000, rp, ctx(36'h1_2345_6, 3'd2, 8'h0F, 2'd2, 1, 1), 3, 2, 0);
    // R3: root absent
    rp[0] = 1'b0;
    lookup(8'h10, 8'h18, 48'h0000_0010_0000, rp, ctx(36'h1, 3'd1, 8'h01, 2'd0, 1, 1), 1, 1, 0);
    rp[0] = 1'b1;
    // R5 R9: context absent, no fpd then fpd
    lookup(8'h01, 8'hA0, 48'h0000_0020_0000, rp, ctx(36'h7, 3'd1, 8'h02, 2'd1, 0, 0), 0, 0, 0);
    lookup(8'h02, 8'hB0, 48'h0000_0020_0000, rp, ctx(36'h7, 3'd1, 8'h02, 2'd1, 1, 0), 2, 0, 0);
    // R8: malformed width codes and type
    lookup(8'h03, 8'hC8, 48'h0000_0030_0000, rp, ctx(36'h9, 3'd5, 8'h03, 2'd0, 0, 1), 0, 1, 0);
    lookup(8'h04, 8'hD0, 48'h0000_0030_0000, rp, ctx(36'h9, 3'd7, 8'h03, 2'd0, 1, 1), 1, 0, 0);
    lookup(8'h05, 8'hD8, 48'h0000_0030_0000, rp, ctx(36'h9, 3'd2, 8'h03, 2'd3, 1, 1), 0, 0, 0);
    // R7: remaining width codes, all-requests type, upper domain bits ignored (R6)
    lookup(8'h06, 8'hE0, 48'h0000_0040_0000, rp, ctx(36'h3_3333_3, 3'd0, 8'hF7, 2'd1, 0, 1), 0, 0, 0);
    lookup(8'h07, 8'hF8, 48'h0000_0040_0000, rp, ctx(36'h4_4444_4, 3'd3, 8'hA9, 2'd0, 0, 1), 1, 0, 0);
    lookup(8'h08, 8'hFA, 48'h0000_0040_0000, rp, ctx(36'h5_5555_5, 3'd4, 8'h6C, 2'd2, 0, 1), 0, 3, 0);
    // R10: requests while busy are ignored
    lookup(8'h20, 8'h40, 48'h0000_0050_0000, rp, ctx(36'h6_6666_6, 3'd1, 8'h0B, 2'd0, 0, 1), 2, 1, 1);
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R10 idle after last handshake", {63'd0, busy}, 0);
    check(sb_q.size() == 0, "R10 all results seen", sb_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule